// File: doc/BRIEF.md
# Latched Event Status Register

This block collects single-cycle event pulses from an instrument's control logic into an 8-bit sticky register. Once a bit is set it stays set until software reads the register through the status read port, or until a clear-all strobe empties it. A read hands back the value held before the clear, so no event is reported twice and none is missed. An event pulse that lands in the same cycle as a clear survives that clear.

An 8-bit enable mask, written and read back through its own port, chooses which latched events feed one registered summary output. A later service-request stage consumes that output. Only six bit positions exist: power-on (7), command error (5), execution error (4), device-dependent error (3), query error (2) and operation complete (0). Bits 6 and 1 always read 0 in both registers.

A small power-up sequencer posts the power-on event exactly once after reset. It has three states. `PU_ARM` is the reset state. `PU_POST` asserts the internal power-on pulse for one cycle. `PU_RUN` is terminal. The transitions are ARM→POST on the first clock edge after reset is released, POST→RUN on the next edge, and RUN→RUN from then on.

Top module: `evt_status_latch`

## Requirements
- R1: While reset is asserted, the event readback, the enable readback and the summary output are all 0.
- R2: The power-on event (bit 7) becomes visible on the event readback after the second rising edge following reset release. It is posted only once: after it has been cleared, it does not return while reset stays high.
- R3: A one-cycle pulse on a command error, execution error, device-dependent error, query error or operation complete input sets bit 5, 4, 3, 2 or 0 respectively, visible after the next rising edge.
- R4: A set event bit stays set on later cycles while no read strobe and no clear-all strobe is given.
- R5: In the cycle the read strobe is high, the event readback shows the value before the clear. After that edge the register is 0, unless an event arrived in the same cycle (see R7).
- R6: A one-cycle clear-all strobe makes the event register 0 after the next rising edge.
- R7: An event pulse given in the same cycle as a read strobe or a clear-all strobe is set in the register after that edge.
- R8: Bits 6 and 1 read 0 on the event readback and on the enable readback at all times.
- R9: An enable write stores the write data with bits 6 and 1 forced to 0, so writing 0xFF reads back 0xBD. Writing 0 clears the enable register.
- R10: The enable register is left unchanged by the read strobe and by the clear-all strobe.
- R11: The summary output is registered. It equals the OR over all bits of (event AND enable) as they stood one clock cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cmd_err_i | input | 1 | Command error event pulse (bit 5) |
| exe_err_i | input | 1 | Execution error event pulse (bit 4) |
| dev_err_i | input | 1 | Device-dependent error event pulse (bit 3) |
| qry_err_i | input | 1 | Query error event pulse (bit 2) |
| op_done_i | input | 1 | Operation complete event pulse (bit 0) |
| rd_stb_i | input | 1 | Status read strobe, clears the register at the edge |
| rd_data_o | output | 8 | Event register value (before clear) |
| clr_all_i | input | 1 | Clear-all strobe for the event register |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| en_rdata_o | output | 8 | Enable register readback |
| summary_o | output | 1 | Registered masked summary |

## Verification
The assertions assume that reset is low from time zero and through the first clock edge. Their `$past` terms therefore always see reset values. They also assume that event inputs are single-cycle pulses driven between edges. The bench holds reset low for several cycles at start-up and changes every input only on the falling edge. Events, strobes and enable writes are each raised for exactly one cycle. They overlap only in the scenarios that deliberately collide an event with a clear.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
    localparam int EVW     = 8;
    localparam int BIT_OPC = 0;
    localparam int BIT_QRY = 2;
    localparam int BIT_DEV = 3;
    localparam int BIT_EXE = 4;
    localparam int BIT_CMD = 5;
    localparam int BIT_PWR = 7;
    localparam logic [EVW-1:0] IMPL_MASK = 8'hBD;

    typedef enum logic [1:0] {
        PU_ARM  = 2'd0,
        PU_POST = 2'd1,
        PU_RUN  = 2'd2
    } pu_state_e;
endpackage

// File: rtl/evt_pwrup_seq.sv
module evt_pwrup_seq
    import evt_status_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    output pu_state_e state_o,
    output logic      pwr_pulse_o
);
    pu_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PU_ARM:  state_d = PU_POST;
            PU_POST: state_d = PU_RUN;
            PU_RUN:  state_d = PU_RUN;
            default: state_d = PU_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PU_ARM;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        pwr_pulse_o = 1'b0;
        unique case (state_q)
            PU_ARM:  pwr_pulse_o = 1'b0;
            PU_POST: pwr_pulse_o = 1'b1;
            PU_RUN:  pwr_pulse_o = 1'b0;
            default: pwr_pulse_o = 1'b0;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/evt_latch_bank.sv
module evt_latch_bank #(
    parameter int               W    = 8,
    parameter logic [W-1:0]     MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_impl
            logic bit_q;
            // a set in the clear cycle wins over the clear
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        bit_q <= 1'b0;
                else if (set_i[i]) bit_q <= 1'b1;
                else if (clr_i)    bit_q <= 1'b0;
            end
            assign q_o[i] = bit_q;
        end else begin : g_void
            assign q_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/evt_enable_reg.sv
module evt_enable_reg #(
    parameter int           W    = 8,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] en_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    en_q <= '0;
        else if (wr_i) en_q <= wdata_i & MASK;
    end
    assign q_o = en_q;
endmodule

// File: rtl/evt_summary_reg.sv
module evt_summary_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_i,
    input  logic [W-1:0] en_i,
    output logic         sum_o
);
    logic sum_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= 1'b0;
        else        sum_q <= |(ev_i & en_i);
    end
    assign sum_o = sum_q;
endmodule

// File: rtl/evt_status_latch.sv
module evt_status_latch
    import evt_status_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_err_i,
    input  logic           exe_err_i,
    input  logic           dev_err_i,
    input  logic           qry_err_i,
    input  logic           op_done_i,
    input  logic           rd_stb_i,
    output logic [EVW-1:0] rd_data_o,
    input  logic           clr_all_i,
    input  logic           en_wr_i,
    input  logic [EVW-1:0] en_wdata_i,
    output logic [EVW-1:0] en_rdata_o,
    output logic           summary_o
);
    pu_state_e      pu_state;
    logic           pwr_pulse;
    logic [EVW-1:0] set_vec;
    logic [EVW-1:0] ev_q;
    logic [EVW-1:0] en_q;
    logic           clr_any;

    evt_pwrup_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_o     (pu_state),
        .pwr_pulse_o (pwr_pulse)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[BIT_PWR] = pwr_pulse;
        set_vec[BIT_CMD] = cmd_err_i;
        set_vec[BIT_EXE] = exe_err_i;
        set_vec[BIT_DEV] = dev_err_i;
        set_vec[BIT_QRY] = qry_err_i;
        set_vec[BIT_OPC] = op_done_i;
    end

    assign clr_any = rd_stb_i | clr_all_i;

    evt_latch_bank #(.W(EVW), .MASK(IMPL_MASK)) u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_any),
        .q_o   (ev_q)
    );

    evt_enable_reg #(.W(EVW), .MASK(IMPL_MASK)) u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (en_wr_i),
        .wdata_i (en_wdata_i),
        .q_o     (en_q)
    );

    evt_summary_reg #(.W(EVW)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .ev_i  (ev_q),
        .en_i  (en_q),
        .sum_o (summary_o)
    );

    assign rd_data_o  = ev_q;
    assign en_rdata_o = en_q;
endmodule

// File: rtl/evt_status_latch_chk.sv
module evt_status_latch_chk
    import evt_status_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           rd_stb_i,
    input logic           clr_all_i,
    input logic           en_wr_i,
    input logic [EVW-1:0] en_wdata_i,
    input logic [EVW-1:0] rd_data_o,
    input logic [EVW-1:0] en_rdata_o,
    input logic           summary_o,
    input logic [EVW-1:0] set_vec,
    input pu_state_e      pu_state
);
    AST_PWR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_state == PU_RUN) |=> (pu_state == PU_RUN)); // R2

    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb_i && !clr_all_i) |=> ((rd_data_o & $past(rd_data_o)) == $past(rd_data_o))); // R4

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_stb_i || clr_all_i) && (set_vec == '0)) |=> (rd_data_o == '0)); // R6

    AST_SET_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i || clr_all_i) |=> ((rd_data_o & $past(set_vec)) == $past(set_vec))); // R7

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data_o & ~IMPL_MASK) == '0) && ((en_rdata_o & ~IMPL_MASK) == '0)); // R8

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i |=> (en_rdata_o == ($past(en_wdata_i) & IMPL_MASK))); // R9

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr_i |=> $stable(en_rdata_o)); // R10

    AST_SUMMARY_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        summary_o == $past(|(rd_data_o & en_rdata_o))); // R11
endmodule

bind evt_status_latch evt_status_latch_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_stb_i   (rd_stb_i),
    .clr_all_i  (clr_all_i),
    .en_wr_i    (en_wr_i),
    .en_wdata_i (en_wdata_i),
    .rd_data_o  (rd_data_o),
    .en_rdata_o (en_rdata_o),
    .summary_o  (summary_o),
    .set_vec    (set_vec),
    .pu_state   (pu_state)
);

// File: tb/evt_status_latch_bench.sv
`timescale 1ns/1ps
module evt_status_latch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_err_i = 0, exe_err_i = 0, dev_err_i = 0, qry_err_i = 0, op_done_i = 0;
    logic       rd_stb_i = 0, clr_all_i = 0, en_wr_i = 0;
    logic [7:0] en_wdata_i = 0;
    logic [7:0] rd_data_o, en_rdata_o;
    logic       summary_o;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    evt_status_latch u_evt_status_latch (
        .clk(clk), .rst_n(rst_n),
        .cmd_err_i(cmd_err_i), .exe_err_i(exe_err_i), .dev_err_i(dev_err_i),
        .qry_err_i(qry_err_i), .op_done_i(op_done_i),
        .rd_stb_i(rd_stb_i), .rd_data_o(rd_data_o), .clr_all_i(clr_all_i),
        .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i), .en_rdata_o(en_rdata_o),
        .summary_o(summary_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // advance one rising edge, land 1 ns after the next falling edge
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic drop_all();
        cmd_err_i = 0; exe_err_i = 0; dev_err_i = 0; qry_err_i = 0; op_done_i = 0;
        rd_stb_i = 0; clr_all_i = 0; en_wr_i = 0;
    endtask

    task automatic t_reset();
        repeat (3) tick();
        chk("R1 event", rd_data_o, 8'h00);
        chk("R1 enable", en_rdata_o, 8'h00);
        chk("R1 summary", {7'd0, summary_o}, 8'h00);
    endtask

    task automatic t_power_on();
        rst_n = 1'b1;
        tick();
        chk("R2 not yet", rd_data_o, 8'h00);
        tick();
        chk("R2 posted", rd_data_o, 8'h80);
        rd_stb_i = 1'b1; #0.5;
        chk("R5 pre-clear value", rd_data_o, 8'h80);
        tick(); rd_stb_i = 1'b0;
        chk("R5 cleared", rd_data_o, 8'h00);
        repeat (5) tick();
        chk("R2 once only", rd_data_o, 8'h00);
    endtask

    task automatic t_events();
        cmd_err_i = 1; tick(); cmd_err_i = 0;
        chk("R3 cmd bit5", rd_data_o, 8'h20);
        exe_err_i = 1; tick(); exe_err_i = 0;
        chk("R3 exe bit4", rd_data_o, 8'h30);
        dev_err_i = 1; tick(); dev_err_i = 0;
        chk("R3 dev bit3", rd_data_o, 8'h38);
        qry_err_i = 1; tick(); qry_err_i = 0;
        chk("R3 qry bit2", rd_data_o, 8'h3C);
        op_done_i = 1; tick(); op_done_i = 0;
        chk("R3 opc bit0", rd_data_o, 8'h3D);
        repeat (4) tick();
        chk("R4 sticky", rd_data_o, 8'h3D);
    endtask

    task automatic t_clear_all();
        clr_all_i = 1; tick(); clr_all_i = 0;
        chk("R6 clear-all", rd_data_o, 8'h00);
    endtask

    task automatic t_collide();
        dev_err_i = 1; tick(); dev_err_i = 0;
        op_done_i = 1; rd_stb_i = 1; #0.5;
        chk("R5 read before clear", rd_data_o, 8'h08);
        tick(); drop_all();
        chk("R7 event kept over read", rd_data_o, 8'h01);
        cmd_err_i = 1; clr_all_i = 1; tick(); drop_all();
        chk("R7 event kept over clear-all", rd_data_o, 8'h20);
        clr_all_i = 1; tick(); clr_all_i = 0;
    endtask

    task automatic t_enable();
        en_wr_i = 1; en_wdata_i = 8'hFF; tick(); en_wr_i = 0;
        chk("R9 R8 masked write", en_rdata_o, 8'hBD);
        en_wr_i = 1; en_wdata_i = 8'h42; tick(); en_wr_i = 0;
        chk("R8 only unimpl bits", en_rdata_o, 8'h00);
        en_wr_i = 1; en_wdata_i = 8'h24; tick(); en_wr_i = 0;
        chk("R9 readback", en_rdata_o, 8'h24);
        rd_stb_i = 1; tick(); rd_stb_i = 0;
        clr_all_i = 1; tick(); clr_all_i = 0;
        chk("R10 enable kept", en_rdata_o, 8'h24);
        en_wr_i = 1; en_wdata_i = 8'h00; tick(); en_wr_i = 0;
        chk("R9 write zero", en_rdata_o, 8'h00);
    endtask

    task automatic t_summary();
        en_wr_i = 1; en_wdata_i = 8'h08; tick(); en_wr_i = 0;
        chk("R11 idle low", {7'd0, summary_o}, 8'h00);
        dev_err_i = 1; tick(); dev_err_i = 0;
        chk("R11 one cycle lag", {7'd0, summary_o}, 8'h00);
        tick();
        chk("R11 rises", {7'd0, summary_o}, 8'h01);
        en_wr_i = 1; en_wdata_i = 8'h01; tick(); en_wr_i = 0;
        chk("R11 still old", {7'd0, summary_o}, 8'h01);
        tick();
        chk("R11 masked off", {7'd0, summary_o}, 8'h00);
        op_done_i = 1; tick(); op_done_i = 0;
        tick();
        chk("R11 other bit", {7'd0, summary_o}, 8'h01);
        clr_all_i = 1; tick(); clr_all_i = 0;
        tick();
        chk("R11 after clear", {7'd0, summary_o}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_power_on();
        t_events();
        t_clear_all();
        t_collide();
        t_enable();
        t_summary();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule